// File: doc/BRIEF.md
# Daisy-chain serial configuration streamer

This block feeds one merged configuration image to a chain of devices that are loaded serially, one behind the other. When started, it first emits a 40-bit header. The header carries a single length value that covers the whole chain. The block then passes the concatenated data bits of all devices through from a ready/valid bit source, with the first device in the chain first. It finishes with a run of trailing '1' bits. The serial bit leaves on `sdo_o`, and `cclk_en_o` marks every cycle in which a configuration clock pulse should be issued for that bit.

The header is sent most significant bit first. It consists of eight '1' bits, the start code `0010`, a 24-bit length, and four '1' bits. The length equals the data bit count plus 40 plus the number of devices. The trailing run holds one '1' bit per device, which the length counts, followed by `PAD_BITS` further '1' clocks that the length does not count. If the length does not fit in 24 bits, the job is refused before any bit is sent.

Top module: `cfg_chain_streamer`

## Requirements
- R1: After an accepted start, the first 40 bits qualified by `cclk_en_o` are, in order, `11111111`, `0010`, the 24-bit length (MSB first), then `1111`.
- R2: The length field equals `total_bits_i + 40 + num_dev_i` as an unsigned 24-bit number.
- R3: Data bits follow the header in the order they are accepted, and a bit is accepted only in a cycle where `din_valid_i` and `din_ready_o` are both high. An accepted bit appears on `sdo_o` with `cclk_en_o` high in the next cycle.
- R4: A cycle with `din_ready_o` high and `din_valid_i` low gives no configuration clock in the following cycle and consumes no data bit.
- R5: After the last data bit, exactly `num_dev_i + PAD_BITS` bits of '1' are sent, and then no further clock enables occur.
- R6: With `total_bits_i` equal to 0, the header is followed directly by the trailing run and `din_ready_o` never rises.
- R7: `busy_o` is high from the cycle after an accepted start through the last serial bit. `done_o` is high for exactly one cycle, the cycle after the last bit, with `busy_o` low.
- R8: If the length would exceed 2^24-1, `err_o` is high for exactly the one cycle after the start, `busy_o` stays low and no clock enable is produced.
- R9: `start_i` has no effect while a job is running.
- R10: During and right after reset, all outputs are low.
- R11: `din_ready_o` is high only during the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a job when idle |
| total_bits_i | input | TOT_W | Sum of all device data bits, sampled at start |
| num_dev_i | input | DEV_W | Devices in the chain, sampled at start |
| din_i | input | 1 | Next data bit of the merged image |
| din_valid_i | input | 1 | `din_i` holds a bit |
| din_ready_o | output | 1 | Block takes a bit this cycle if valid |
| sdo_o | output | 1 | Serial configuration data |
| cclk_en_o | output | 1 | Issue a configuration clock for `sdo_o` |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| err_o | output | 1 | One-cycle pulse: length overflow, job refused |

## Verification
The assertions assume that `total_bits_i` and `num_dev_i` are meaningful only in the cycle where `start_i` is sampled in idle. They also assume that the source never offers more data bits than the declared count, because `din_ready_o` falls as soon as the count runs out. The stimulus holds the inputs steady across the start cycle and raises valid only while its own index is below the declared count. Valid may be withheld for arbitrary stretches, and a stray start pulse is issued in the middle of one job.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

    localparam int HDR_BITS = 40;
    localparam int LEN_W    = 24;

    localparam logic [7:0] PREAMBLE   = 8'hFF;
    localparam logic [3:0] START_CODE = 4'b0010;
    localparam logic [3:0] TAIL_CODE  = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_PAD,
        ST_DONE
    } st_e;

    function automatic logic [HDR_BITS-1:0] make_hdr(input logic [LEN_W-1:0] len);
        return {PREAMBLE, START_CODE, len, TAIL_CODE};
    endfunction

endpackage

// File: rtl/cfg_len_calc.sv
module cfg_len_calc
    import cfg_chain_pkg::*;
#(
    parameter int TOT_W = 32,
    parameter int DEV_W = 4
) (
    input  logic [TOT_W-1:0] total_i,
    input  logic [DEV_W-1:0] ndev_i,
    output logic [LEN_W-1:0] len_o,
    output logic             ovf_o
);
    localparam int SUM_W = TOT_W + 2;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum   = {2'b00, total_i} + SUM_W'(HDR_BITS) + SUM_W'(ndev_i);
        len_o = sum[LEN_W-1:0];
        ovf_o = |sum[SUM_W-1:LEN_W];
    end

endmodule

// File: rtl/cfg_hdr_shift.sv
module cfg_hdr_shift
    import cfg_chain_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [HDR_BITS-1:0] load_val_i,
    input  logic                shift_i,
    output logic                msb_o
);
    logic [HDR_BITS-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load_i)
            sr_d = load_val_i;
        else if (shift_i)
            sr_d = {sr_q[HDR_BITS-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign msb_o = sr_q[HDR_BITS-1];

    // R1: the header register is never reloaded while it is being shifted out
    a_r1_load_shift_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i));

endmodule

// File: rtl/cfg_chain_streamer.sv
module cfg_chain_streamer
    import cfg_chain_pkg::*;
#(
    parameter int TOT_W    = 32,
    parameter int DEV_W    = 4,
    parameter int PAD_BITS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [TOT_W-1:0] total_bits_i,
    input  logic [DEV_W-1:0] num_dev_i,
    input  logic             din_i,
    input  logic             din_valid_i,
    output logic             din_ready_o,
    output logic             sdo_o,
    output logic             cclk_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int HCNT_W = $clog2(HDR_BITS);
    localparam int PAD_W  = $clog2((1 << DEV_W) + PAD_BITS + 1);

    typedef struct packed {
        st_e               st;
        logic [HCNT_W-1:0] hcnt;
        logic [TOT_W-1:0]  rem;
        logic [PAD_W-1:0]  pad;
        logic              sdo;
        logic              en;
        logic              busy;
        logic              done;
        logic              err;
    } reg_t;

    reg_t r_d, r_q;

    logic [LEN_W-1:0] len;
    logic             ovf;
    logic             hdr_load, hdr_shift, hdr_msb;

    cfg_len_calc #(.TOT_W(TOT_W), .DEV_W(DEV_W)) i_len (
        .total_i (total_bits_i),
        .ndev_i  (num_dev_i),
        .len_o   (len),
        .ovf_o   (ovf)
    );

    cfg_hdr_shift i_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (hdr_load),
        .load_val_i (make_hdr(len)),
        .shift_i    (hdr_shift),
        .msb_o      (hdr_msb)
    );

    always_comb begin
        r_d       = r_q;
        r_d.en    = 1'b0;
        r_d.sdo   = 1'b0;
        r_d.done  = 1'b0;
        r_d.err   = 1'b0;
        hdr_load  = 1'b0;
        hdr_shift = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.busy = 1'b0;
                if (start_i) begin
                    if (ovf) begin
                        r_d.err = 1'b1;
                    end else begin
                        hdr_load = 1'b1;
                        r_d.st   = ST_HDR;
                        r_d.hcnt = HCNT_W'(HDR_BITS - 1);
                        r_d.rem  = total_bits_i;
                        r_d.pad  = PAD_W'(num_dev_i) + PAD_W'(PAD_BITS - 1);
                        r_d.busy = 1'b1;
                    end
                end
            end
            ST_HDR: begin
                r_d.en    = 1'b1;
                r_d.sdo   = hdr_msb;
                hdr_shift = 1'b1;
                r_d.hcnt  = r_q.hcnt - HCNT_W'(1);
                if (r_q.hcnt == '0)
                    r_d.st = (r_q.rem == '0) ? ST_PAD : ST_DATA;
            end
            ST_DATA: begin
                if (din_valid_i) begin
                    r_d.en  = 1'b1;
                    r_d.sdo = din_i;
                    r_d.rem = r_q.rem - TOT_W'(1);
                    if (r_q.rem == TOT_W'(1))
                        r_d.st = ST_PAD;
                end
            end
            ST_PAD: begin
                r_d.en  = 1'b1;
                r_d.sdo = 1'b1;
                r_d.pad = r_q.pad - PAD_W'(1);
                if (r_q.pad == '0)
                    r_d.st = ST_DONE;
            end
            ST_DONE: begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign din_ready_o = (r_q.st == ST_DATA);
    assign sdo_o       = r_q.sdo;
    assign cclk_en_o   = r_q.en;
    assign busy_o      = r_q.busy;
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;

    // R7: every configuration clock falls inside a busy window
    a_r7_en_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_en_o |-> busy_o);

    // R7: done is a single-cycle pulse that ends a busy window
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    // R4: a stalled data cycle yields no clock next cycle
    a_r4_stall_no_clk: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ready_o && !din_valid_i) |=> !cclk_en_o);

    // R3: an accepted bit is clocked out next cycle unchanged
    a_r3_accept_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ready_o && din_valid_i) |=> (cclk_en_o && (sdo_o == $past(din_i))));

    // R8: a refused job never looks busy
    a_r8_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !cclk_en_o));

    // R11: ready only while a job runs
    a_r11_ready_in_job: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready_o |-> busy_o);

endmodule

// File: tb/test_cfg_chain_streamer.sv
`timescale 1ns/1ps
module test_cfg_chain_streamer;
    localparam int TOT_W    = 32;
    localparam int DEV_W    = 4;
    localparam int PAD_BITS = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [TOT_W-1:0] total_bits_i = '0;
    logic [DEV_W-1:0] num_dev_i = '0;
    logic             din_i = 1'b0;
    logic             din_valid_i = 1'b0;
    logic             din_ready_o, sdo_o, cclk_en_o, busy_o, done_o, err_o;

    always #2.5 clk = ~clk;

    cfg_chain_streamer #(.TOT_W(TOT_W), .DEV_W(DEV_W), .PAD_BITS(PAD_BITS)) i_cfg_chain_streamer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_bits_i(total_bits_i),
        .num_dev_i(num_dev_i), .din_i(din_i), .din_valid_i(din_valid_i),
        .din_ready_o(din_ready_o), .sdo_o(sdo_o), .cclk_en_o(cclk_en_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int total_checks = 0;
    int bad = 0;
    int cycles = 0;
    bit exp_q[$];
    int pos = 0;
    int job_total = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total_checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total_checks, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // reference stream comparison on every clock
    always @(negedge clk) begin
        if (rst_n && cclk_en_o) begin
            string tag;
            bit e;
            if (pos < 12 || (pos >= 36 && pos < 40)) tag = "R1";
            else if (pos < 40)                       tag = "R2";
            else if (pos < 40 + job_total)           tag = "R3";
            else                                     tag = "R5";
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 extra clock", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(sdo_o === e, tag, int'(sdo_o), int'(e));
                check(busy_o === 1'b1, "R7 busy during bit", int'(busy_o), 1);
            end
            pos++;
        end
    end

    function automatic bit data_bit(input int i, input int mode);
        return (((i * 7) + (mode * 3)) % 5) < 2;
    endfunction

    function automatic bit valid_pat(input int cyc, input int mode);
        if (mode == 0) return 1'b1;
        return (cyc % 3) != 0;
    endfunction

    task automatic run_job(input int total, input int ndev, input int mode);
        bit [39:0] hdr;
        bit [23:0] len;
        bit dq[$];
        int idx = 0;
        int cyc = 0;
        bit hs = 1'b0;
        bit v;
        bit stall_prev = 1'b0;
        bit saw_ready = 1'b0;

        exp_q.delete();
        pos = 0;
        job_total = total;
        len = 24'(total + 40 + ndev);
        hdr = {8'hFF, 4'b0010, len, 4'hF};
        for (int i = 39; i >= 0; i--) exp_q.push_back(hdr[i]);
        for (int i = 0; i < total; i++) begin
            dq.push_back(data_bit(i, mode));
            exp_q.push_back(data_bit(i, mode));
        end
        for (int i = 0; i < ndev + PAD_BITS; i++) exp_q.push_back(1'b1);

        @(negedge clk);
        total_bits_i = TOT_W'(total);
        num_dev_i    = DEV_W'(ndev);
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R7 busy after start", int'(busy_o), 1);

        while (cyc < 5000) begin
            if (stall_prev)
                check(cclk_en_o === 1'b0, "R4 stall clock", int'(cclk_en_o), 0);
            if (hs) idx++;
            if (din_ready_o) saw_ready = 1'b1;
            v = (idx < total) && valid_pat(cyc, mode);
            din_valid_i = v;
            din_i       = v ? dq[idx] : 1'b0;
            hs          = v && din_ready_o;
            stall_prev  = din_ready_o && !v;
            start_i     = (mode == 2) && (cyc == 30 || cyc == 60);
            @(negedge clk);
            cyc++;
            if (done_o) break;
        end
        start_i = 1'b0;
        din_valid_i = 1'b0;
        check(done_o === 1'b1, "R7 done seen", int'(done_o), 1);
        check(exp_q.size() == 0, "R5 all bits sent", exp_q.size(), 0);
        check(idx == total, "R3 bits accepted", idx, total);
        check(busy_o === 1'b0, "R7 busy low at done", int'(busy_o), 0);
        check(din_ready_o === 1'b0, "R11 ready after job", int'(din_ready_o), 0);
        if (total == 0)
            check(!saw_ready, "R6 ready never high", int'(saw_ready), 0);
        if (mode == 2)
            check(pos == 40 + total + ndev + PAD_BITS, "R9 no restart", pos, 40 + total + ndev + PAD_BITS);
        @(negedge clk);
        check(done_o === 1'b0, "R7 done one cycle", int'(done_o), 0);
        check(busy_o === 1'b0, "R9 idle after job", int'(busy_o), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({sdo_o, cclk_en_o, busy_o, done_o, err_o, din_ready_o} == 6'b0, "R10 reset outputs",
              int'({sdo_o, cclk_en_o, busy_o, done_o, err_o, din_ready_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({cclk_en_o, busy_o, done_o, err_o, din_ready_o} == 5'b0, "R10 after release",
              int'({cclk_en_o, busy_o, done_o, err_o, din_ready_o}), 0);

        run_job(37, 3, 0);
        run_job(50, 5, 1);
        run_job(0, 2, 0);
        run_job(8, 0, 1);
        run_job(45, 4, 2);
        run_job(29, 15, 1);

        // R8: length one above the 24-bit limit
        exp_q.delete();
        pos = 0;
        @(negedge clk);
        total_bits_i = TOT_W'((1 << 24) - 40 - 3);
        num_dev_i    = DEV_W'(3);
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o === 1'b1, "R8 err pulse", int'(err_o), 1);
        check(busy_o === 1'b0, "R8 not busy", int'(busy_o), 0);
        @(negedge clk);
        check(err_o === 1'b0, "R8 err one cycle", int'(err_o), 0);
        repeat (5) @(negedge clk);
        check(pos == 0, "R8 no bits sent", pos, 0);
        check(busy_o === 1'b0, "R8 idle", int'(busy_o), 0);

        run_job(12, 1, 0);
        finish_run();
    end

endmodule